// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter with Frame Check Sequence

This block turns bytes written by a host into a bit-synchronous frame of the HDLC/SDLC family. While nothing is queued, the line carries back-to-back flag octets (0x7E). The first byte that the host places in the single holding register goes out after the flag in progress, and that flag serves as the opening flag. Further bytes follow with no gap as long as the host refills the holding register in time. Data and check bits go through zero-bit insertion, so a receiver never sees six ones in a row outside a flag. One serial bit leaves per cycle in which the bit-clock enable is high.

The host sees a byte write port and an active-low stall output. The stall goes low while the host tries to write into a full holding register, so the host can stretch its write until the register drains. Three controls manage the check sequence:
- a strobe presets the 16-bit CRC;
- a level includes data bits in the CRC;
- a strobe clears the end-of-message latch.

When the transmitter runs out of data after that latch has been cleared, it closes the frame itself. It sends the complemented CRC and then a flag, and it sets the latch again, which the host reads as end of message.

Top module: `hdlc_tx`

## Requirements
- R1: After synchronous reset, `tx_bit` is 1, `eom` is 1, `wait_n` is 1, the holding register is empty and the first bit sent is the first bit of a flag.
- R2: With nothing written, the line sends continuous flags, each the bit sequence 0,1,1,1,1,1,1,0. Exactly one bit is produced at each clock edge where `bit_en` is 1, and `tx_bit` holds its value when `bit_en` is 0.
- R3: `wait_n` is 0 exactly while `wr_en` is 1 and the holding register is full. A write is taken at a clock edge where `wr_en` is 1 and `wait_n` is 1. The holding register empties when its byte is loaded for sending.
- R4: A held byte is loaded when the flag or data byte in progress ends. Data bytes are sent most significant bit first and back to back while the holding register is refilled in time.
- R5: After five consecutive 1 bits of data or check sequence, counted across byte boundaries, a 0 is inserted. Flag bits never receive insertion and reset the count. A run of five that ends a data or check byte gets its 0 before the next flag.
- R6: `crc_reset` presets the CRC register to 0xFFFF. While `crc_en` is 1, each sent data bit (not inserted zeros) updates the register with polynomial 0x1021, non-reflected: feedback = crc[15] XOR bit, crc = (crc << 1) XOR (feedback ? 0x1021 : 0).
- R7: If the holding register is empty when a data byte ends, `eom` is 0 and `crc_en` is 1, the block sends 16 check bits, the complement of the CRC most significant bit first, and then flags. `eom` becomes 1 at the edge the check sequence starts, and the CRC register is back at 0xFFFF once it has been sent.
- R8: If the holding register is empty when a data byte ends and either `eom` is 1 or `crc_en` is 0, a flag follows directly, with no check sequence, and `eom` is unchanged.
- R9: `eom_clear` sets `eom` to 0 at the next edge unless a check sequence starts at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one line bit per high cycle |
| wr_en | input | 1 | Host write request |
| wr_data | input | 8 | Host write byte |
| wait_n | output | 1 | Active-low stall: write attempted while holding register full |
| crc_reset | input | 1 | Strobe: preset CRC register to all ones |
| crc_en | input | 1 | Level: include data in CRC and permit check-sequence append |
| eom_clear | input | 1 | Strobe: clear end-of-message latch |
| tx_bit | output | 1 | Serial line bit |
| eom | output | 1 | End-of-message latch state |

## Verification
The bench builds the block with its default widths: 8-bit bytes, a 16-bit check register and a run limit of five. It drives the bit-clock enable every cycle, every second cycle and every third cycle, so that host writes and commands land both on and between bit slots. Bytes such as 0xFF, 0x7E, 0x3F and 0xF8 make insertion runs cross byte boundaries and run into the closing flag. The three underrun outcomes are each taken: latch cleared with CRC enabled, latch still set, and CRC disabled.

// File: rtl/hdlc_tx_pkg.sv
// Package: shared types for the frame transmitter.
// Assumes: nothing beyond the standard language.
package hdlc_tx_pkg;
    // Kind of octet currently being serialised.
    typedef enum logic [1:0] {
        SEG_FLAG = 2'd0,
        SEG_DATA = 2'd1,
        SEG_FCS  = 2'd2
    } seg_e;
endpackage

// File: rtl/hdlc_tx_hold.sv
// Module: single-entry transmit holding register with host stall.
// Does: captures a host byte when empty, drops it when the serialiser
// loads it, and drives wait_n low while a write meets a full register.
// Assumes: pop is only raised while full is high.
module hdlc_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic          full,
    output logic [DW-1:0] dout,
    output logic          wait_n
);
    logic          full_q;
    logic [DW-1:0] data_q;
    logic          accept;

    // Take a write only into an empty register.
    always_comb accept = wr_en && !full_q;

    // Holding register fill and drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

    assign full   = full_q;
    assign dout   = data_q;
    assign wait_n = !(wr_en && full_q);
endmodule

// File: rtl/hdlc_tx_crc.sv
// Module: serial CRC register for the frame check sequence.
// Does: presets on clear, folds in one data bit per upd, and shifts the
// register out (refilling with ones) per shift_out while the check
// sequence is sent; fcs_bit is the complemented top bit.
// Assumes: upd and shift_out are never high together.
module hdlc_tx_crc #(
    parameter int            CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h1021,
    parameter logic [CW-1:0] INIT = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic upd,
    input  logic din,
    input  logic shift_out,
    output logic fcs_bit
);
    logic [CW-1:0] crc_q;
    logic          fb;

    // Feedback of the non-reflected serial divider.
    always_comb fb = crc_q[CW-1] ^ din;

    // CRC register: preset, accumulate, or shift out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (clear) begin
            crc_q <= INIT;
        end else if (upd) begin
            crc_q <= {crc_q[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (shift_out) begin
            crc_q <= {crc_q[CW-2:0], 1'b1};
        end
    end

    assign fcs_bit = ~crc_q[CW-1];
endmodule

// File: rtl/hdlc_tx_seq.sv
// Module: octet sequencer and zero-bit inserter.
// Does: chooses flag, data or check-sequence octets, serialises them
// MSB first on bit_en, inserts a 0 after RUN_MAX ones outside flags,
// and keeps the end-of-message latch.
// Assumes: CW >= DW; the CRC unit supplies its next check bit on fcs_bit.
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
#(
    parameter int            DW      = 8,
    parameter int            CW      = 16,
    parameter int            RUN_MAX = 5,
    parameter logic [DW-1:0] FLAG    = 8'h7E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    output logic          hold_pop,
    input  logic          crc_en,
    input  logic          fcs_bit,
    output logic          crc_upd,
    output logic          crc_din,
    output logic          crc_shift,
    input  logic          eom_clear,
    output logic          eom,
    output logic          tx_bit
);
    localparam int CNT_W = $clog2(CW);
    localparam int RUN_W = $clog2(RUN_MAX + 1);

    seg_e             seg_q;
    logic [DW-1:0]    sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RUN_W-1:0] run_q;
    logic             eom_q;
    logic             tx_q;

    logic stuff_now, step, cur_bit, last, end_oct, go_fcs;

    // Per-slot decisions: insertion, octet end and what comes next.
    always_comb begin
        stuff_now = bit_en && (run_q == RUN_W'(RUN_MAX));
        step      = bit_en && !stuff_now;
        cur_bit   = (seg_q == SEG_FCS) ? fcs_bit : sh_q[DW-1];
        last      = (seg_q == SEG_FCS) ? (cnt_q == CNT_W'(CW - 1))
                                       : (cnt_q == CNT_W'(DW - 1));
        end_oct   = step && last;
        hold_pop  = end_oct && (seg_q != SEG_FCS) && hold_full;
        go_fcs    = end_oct && (seg_q == SEG_DATA) && !hold_full
                    && !eom_q && crc_en;
        crc_upd   = step && (seg_q == SEG_DATA) && crc_en;
        crc_din   = cur_bit;
        crc_shift = step && (seg_q == SEG_FCS);
    end

    // Serialiser: line bit, run count, bit counter and octet selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= SEG_FLAG;
            sh_q  <= FLAG;
            cnt_q <= '0;
            run_q <= '0;
            tx_q  <= 1'b1;
        end else if (stuff_now) begin
            tx_q  <= 1'b0;
            run_q <= '0;
        end else if (step) begin
            tx_q  <= cur_bit;
            run_q <= (seg_q != SEG_FLAG && cur_bit) ? run_q + RUN_W'(1) : '0;
            if (last) begin
                cnt_q <= '0;
                if (hold_pop) begin
                    seg_q <= SEG_DATA;
                    sh_q  <= hold_data;
                end else if (go_fcs) begin
                    seg_q <= SEG_FCS;
                end else begin
                    seg_q <= SEG_FLAG;
                    sh_q  <= FLAG;
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                sh_q  <= {sh_q[DW-2:0], 1'b0};
            end
        end
    end

    // End-of-message latch: set by check-sequence start, cleared by host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eom_q <= 1'b1;
        end else if (go_fcs) begin
            eom_q <= 1'b1;
        end else if (eom_clear) begin
            eom_q <= 1'b0;
        end
    end

    assign eom    = eom_q;
    assign tx_bit = tx_q;
endmodule

// File: rtl/hdlc_tx.sv
// Module: bit-oriented frame transmitter top.
// Does: joins the holding register, the CRC unit and the sequencer.
// Assumes: the host presets the CRC before a frame and clears the
// end-of-message latch once the frame is under way.
module hdlc_tx #(
    parameter int DW      = 8,
    parameter int CW      = 16,
    parameter int RUN_MAX = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wait_n,
    input  logic          crc_reset,
    input  logic          crc_en,
    input  logic          eom_clear,
    output logic          tx_bit,
    output logic          eom
);
    localparam logic [DW-1:0] FLAG_OCT = DW'(8'h7E);
    localparam logic [CW-1:0] CRC_POLY = CW'(16'h1021);

    logic          hold_full;
    logic          hold_pop;
    logic [DW-1:0] hold_data;
    logic          crc_upd, crc_din, crc_shift, fcs_bit;

    hdlc_tx_hold #(.DW(DW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .pop    (hold_pop),
        .full   (hold_full),
        .dout   (hold_data),
        .wait_n (wait_n)
    );

    hdlc_tx_crc #(.CW(CW), .POLY(CRC_POLY), .INIT('1)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (crc_reset),
        .upd      (crc_upd),
        .din      (crc_din),
        .shift_out(crc_shift),
        .fcs_bit  (fcs_bit)
    );

    hdlc_tx_seq #(.DW(DW), .CW(CW), .RUN_MAX(RUN_MAX), .FLAG(FLAG_OCT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .hold_full(hold_full),
        .hold_data(hold_data),
        .hold_pop (hold_pop),
        .crc_en   (crc_en),
        .fcs_bit  (fcs_bit),
        .crc_upd  (crc_upd),
        .crc_din  (crc_din),
        .crc_shift(crc_shift),
        .eom_clear(eom_clear),
        .eom      (eom),
        .tx_bit   (tx_bit)
    );
endmodule

// File: rtl/hdlc_tx_chk.sv
// Module: assertion checker for hdlc_tx, attached by bind below.
// Does: watches the line, the host stall, the latch and the CRC register.
// Assumes: bound to hdlc_tx with its default 16-bit check register.
module hdlc_tx_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          wr_en,
    input logic          wait_n,
    input logic          crc_reset,
    input logic          eom_clear,
    input logic          tx_bit,
    input logic          eom,
    input logic          hold_full,
    input logic          in_fcs,
    input logic [CW-1:0] crc_val
);
    logic       bit_en_d;
    logic [2:0] ones;

    // Count consecutive ones seen on the line, one sample per sent bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_en_d <= 1'b0;
            ones     <= '0;
        end else begin
            bit_en_d <= bit_en;
            if (bit_en_d) begin
                ones <= !tx_bit ? 3'd0 : (ones == 3'd7) ? 3'd7 : ones + 3'd1;
            end
        end
    end

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= 3'd6); // R5
    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit)); // R2
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wait_n) |=> hold_full); // R3
    AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        crc_reset |=> (crc_val == '1)); // R6
    AST_FCS_SETS_EOM: assert property (@(posedge clk) disable iff (!rst_n)
        in_fcs |-> eom); // R7
    AST_EOM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eom) |-> $past(eom_clear)); // R9
endmodule

bind hdlc_tx hdlc_tx_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .wr_en    (wr_en),
    .wait_n   (wait_n),
    .crc_reset(crc_reset),
    .eom_clear(eom_clear),
    .tx_bit   (tx_bit),
    .eom      (eom),
    .hold_full(hold_full),
    .in_fcs   (u_seq.seg_q == hdlc_tx_pkg::SEG_FCS),
    .crc_val  (u_crc.crc_q)
);

// File: tb/hdlc_tx_bench.sv
// Bench: behavioural queue model of the line, compared every clock.
module hdlc_tx_bench;
    logic       clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, wr_en = 1'b0;
    logic       crc_reset = 1'b0, crc_en = 1'b0, eom_clear = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wait_n, tx_bit, eom;

    always #10 clk = ~clk;

    hdlc_tx u_hdlc_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en),
        .wr_data(wr_data), .wait_n(wait_n), .crc_reset(crc_reset),
        .crc_en(crc_en), .eom_clear(eom_clear), .tx_bit(tx_bit), .eom(eom)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int div     = 1;
    int cyc     = 0;

    // Reference model state: pending line bits and their kinds
    // (0 flag, 1 data, 2 check sequence, 3 inserted zero).
    bit          mq_v[$];
    int          mq_k[$];
    int          cur_k, last_k, m_run;
    bit          m_bit, m_eom, m_full;
    logic [15:0] m_crc;
    logic [7:0]  m_hold;

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_oct(input logic [7:0] v, input int k);
        for (int i = 7; i >= 0; i--) begin
            mq_v.push_back(v[i]);
            mq_k.push_back(k);
        end
    endtask

    // Model update at each edge from the inputs driven on the prior negedge.
    always @(posedge clk) begin
        bit b; int k; bit accept; bit popped; bit set_eom;
        if (!rst_n) begin
            mq_v.delete(); mq_k.delete();
            push_oct(8'h7E, 0);
            cur_k = 0; last_k = 0; m_run = 0; m_bit = 1'b1; m_eom = 1'b1;
            m_full = 1'b0; m_hold = 8'h00; m_crc = 16'hFFFF;
        end else begin
            accept = wr_en && !m_full; popped = 1'b0; set_eom = 1'b0;
            if (bit_en) begin
                if (m_run == 5) begin
                    m_bit = 1'b0; m_run = 0; last_k = 3;
                end else begin
                    b = mq_v.pop_front(); k = mq_k.pop_front();
                    m_bit = b; last_k = k;
                    if (k == 0) m_run = 0; else m_run = b ? m_run + 1 : 0;
                    if (k == 1 && crc_en)
                        m_crc = {m_crc[14:0], 1'b0} ^ ((m_crc[15] ^ b) ? 16'h1021 : 16'h0000);
                    if (mq_v.size() == 0) begin
                        if (cur_k != 2 && m_full) begin
                            push_oct(m_hold, 1); cur_k = 1; popped = 1'b1;
                        end else if (cur_k == 1 && !m_eom && crc_en) begin
                            for (int i = 15; i >= 0; i--) begin
                                mq_v.push_back(~m_crc[i]); mq_k.push_back(2);
                            end
                            m_crc = 16'hFFFF; cur_k = 2; set_eom = 1'b1;
                        end else begin
                            push_oct(8'h7E, 0); cur_k = 0;
                        end
                    end
                end
            end
            if (crc_reset) m_crc = 16'hFFFF;
            if (set_eom) m_eom = 1'b1; else if (eom_clear) m_eom = 1'b0;
            if (popped) m_full = 1'b0;
            if (accept) begin m_full = 1'b1; m_hold = wr_data; end
        end
    end

    // Compare ports with the model away from the edge.
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            case (last_k)
                0:       check("R2 flag bit", tx_bit, m_bit);
                1:       check("R4 data bit", tx_bit, m_bit);
                2:       check("R6 R7 check bit", tx_bit, m_bit);
                default: check("R5 inserted zero", tx_bit, m_bit);
            endcase
            check("R7 R8 R9 eom", eom, m_eom);
            check("R3 wait_n", wait_n, !(wr_en && m_full));
        end
    end

    // Bit-clock enable generator.
    always @(negedge clk) begin
        cyc++;
        bit_en = (div == 1) ? 1'b1 : ((cyc % div) == 0);
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        forever begin
            #1;
            if (wait_n) begin
                @(negedge clk);
                wr_en = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse_crc_reset();
        @(negedge clk); crc_reset = 1'b1;
        @(negedge clk); crc_reset = 1'b0;
    endtask

    task automatic pulse_eom_clear();
        @(negedge clk); eom_clear = 1'b1;
        @(negedge clk); eom_clear = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        check("R1 reset tx_bit", tx_bit, 1'b1);
        check("R1 reset eom", eom, 1'b1);
        check("R1 reset wait_n", wait_n, 1'b1);
        rst_n = 1'b1;
        idle(40);

        // Frame with check sequence, bit every cycle.
        pulse_crc_reset();
        crc_en = 1'b1;
        host_write(8'hA5);
        host_write(8'hFF);
        pulse_eom_clear();
        host_write(8'h3F);
        host_write(8'h7E);
        host_write(8'hF8);
        idle(200);
        check("R7 eom set after check sequence", eom, 1'b1);

        // Latch left set: frame ends straight into a flag.
        div = 3;
        pulse_crc_reset();
        host_write(8'h12);
        host_write(8'hFF);
        idle(300);
        check("R8 eom unchanged without clear", eom, 1'b1);

        // CRC disabled with latch cleared: no check sequence either.
        pulse_eom_clear();
        idle(2);
        check("R9 eom cleared by command", eom, 1'b0);
        crc_en = 1'b0;
        host_write(8'h55);
        host_write(8'hFF);
        idle(300);
        check("R8 eom unchanged with crc disabled", eom, 1'b0);

        // Half-rate frame with runs crossing byte boundaries.
        div = 2;
        crc_en = 1'b1;
        pulse_crc_reset();
        host_write(8'h1F);
        host_write(8'hFF);
        pulse_eom_clear();
        host_write(8'hF0);
        idle(300);
        check("R7 eom set after half-rate frame", eom, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule